// File: doc/BRIEF.md
# Sample-Window Edge Monitor Accumulator

This block is the digital back end of a timing monitor for a slow reference pulse. On every sampling-clock cycle it receives a vector of samples of that pulse. Each bit of the vector was taken by a flop clocked from a differently delayed copy of the sampling clock. Bit 0 comes from the least delayed phase and the top bit from the most delayed one. The block finds rising edges of the reference pulse by watching the most delayed bit. On each such edge it ORs the sample vector into a running accumulator. After a programmable number of edges it publishes the accumulated pattern as the result.

OR-ing captures over many edges widens the pattern by the jitter of the pulse edge, so the result shows the spread of the edge as well as its position. A classifier sorts the published pattern into one of four states:
- a setup/hold violation, where the edge falls inside the sampled window;
- clock leading the reference;
- clock lagging the reference;
- an invalid, non-thermometer pattern.

A small register port sets the number of edges per measurement and reads back the last result.

The sample input is a stream with a valid qualifier and no ready signal. Samples arrive at the sampling-clock rate and cannot be held, so the block accepts every valid sample and never applies back-pressure. The result side is a one-cycle valid pulse with no back-pressure either: the result stays readable on `res_data_o` and through the register port until the next update.

Top module: `swm_edge_monitor`

## Requirements
- R1: After reset, register 0 (poll count) reads 1, register 1 (result) reads 0, `res_data_o` is 0, `res_valid_o` is 0 and `res_state_o` is 2'b01.
- R2: A write with `cfg_addr_i`=0 stores `cfg_wdata_i` as the poll count, and reading address 0 returns it. A written value of 0 is stored and read back as 1.
- R3: Address 1 returns the result register in its low bits and is read-only. A write to address 1 changes neither the result nor the poll count.
- R4: A reference edge is a valid sample whose top bit is 1 when the top bit of the previous valid sample was 0. The "previous top bit" is taken as 1 out of reset, so a pulse already high at reset is not counted.
- R5: On the edge that brings the edge count to the poll count, the result register and `res_data_o` take, at the next clock edge, the OR of the sample vectors of all edges in that window. `res_valid_o` is high for exactly that one cycle.
- R6: Between updates, the result register and `res_data_o` hold their value.
- R7: After each update, the accumulator and edge count clear, and the next window starts with the following edge without any write.
- R8: A write to address 0 clears the accumulator and edge count, so the window restarts. An edge in the same cycle as such a write is not counted.
- R9: `res_state_o` follows the result register at all times:
  - 2'b00 (violation) when it is one or more zeros at bit 0 upward followed by one or more ones up to the top bit;
  - 2'b01 (clock leading) when it is all zeros;
  - 2'b10 (clock lagging) when it is all ones;
  - 2'b11 for any other pattern.
- R10: A sample with `smp_valid_i` low is ignored. It counts as no edge and leaves the remembered top bit unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| smp_valid_i | input | 1 | Sample vector qualifier |
| smp_i | input | NPH (8) | Phase samples of the reference pulse, bit 0 least delayed |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_addr_i | input | 1 | Register select: 0 poll count, 1 result |
| cfg_wdata_i | input | CNT_W (8) | Register write data |
| cfg_rdata_o | output | DW (8) | Register read data for `cfg_addr_i`, combinational |
| res_valid_o | output | 1 | One-cycle pulse on each result update |
| res_data_o | output | NPH (8) | Current result register |
| res_state_o | output | 2 | Classification of the result register |

## Verification
The bench targets the points where an edge could be miscounted:
- Samples with the valid qualifier low sit between a low and a high top bit. A design that updated its edge memory on invalid samples would then miss or invent edges.
- Pulses are held high through reset. A design whose edge memory reset to 0 would count an edge that never happened.

Poll-count writes land mid-window and in the same cycle as an edge. A design that kept the old count or counted the coincident edge would publish one edge early.

Directed patterns cover:
- a window of three different captures, which exposes an AND in place of an OR or a missing accumulator clear;
- write-zero, which would otherwise stall the block forever;
- a write to the read-only result;
- each state code, including ones-then-zeros and gapped patterns, which a loose thermometer check would call a violation.

A constrained-random phase then compares every cycle against the bench's reference model.

// File: rtl/swm_pkg.sv
package swm_pkg;
  typedef enum logic [1:0] {
    ST_VIOL = 2'b00,
    ST_LEAD = 2'b01,
    ST_LAG  = 2'b10,
    ST_BAD  = 2'b11
  } swm_state_e;

  localparam logic ADDR_POLL = 1'b0;
  localparam logic ADDR_RES  = 1'b1;
endpackage

// File: rtl/swm_cfg_regs.sv
module swm_cfg_regs
  import swm_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int NPH   = 8,
  parameter int DW    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we_i,
  input  logic             cfg_addr_i,
  input  logic [CNT_W-1:0] cfg_wdata_i,
  input  logic [NPH-1:0]   res_q_i,
  output logic [CNT_W-1:0] poll_q_o,
  output logic             poll_we_o,
  output logic [DW-1:0]    cfg_rdata_o
);
  localparam logic [CNT_W-1:0] POLL_ONE = CNT_W'(1);

  logic [CNT_W-1:0] poll_q;
  logic [CNT_W-1:0] poll_d;

  // Only the poll-count address is writable; result writes fall away here.
  assign poll_we_o = cfg_we_i && (cfg_addr_i == ADDR_POLL);
  assign poll_d    = (cfg_wdata_i == '0) ? POLL_ONE : cfg_wdata_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      poll_q <= POLL_ONE;
    end else if (poll_we_o) begin
      poll_q <= poll_d;
    end
  end

  always_comb begin
    if (cfg_addr_i == ADDR_POLL) begin
      cfg_rdata_o = DW'(poll_q);
    end else begin
      cfg_rdata_o = DW'(res_q_i);
    end
  end

  assign poll_q_o = poll_q;
endmodule

// File: rtl/swm_edge_det.sv
module swm_edge_det #(
  parameter int NPH = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           smp_valid_i,
  input  logic [NPH-1:0] smp_i,
  output logic           edge_o
);
  localparam int TOP = NPH - 1;

  logic top_prev_q;

  // Reset to 1 so a pulse already high at reset is not taken as an edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      top_prev_q <= 1'b1;
    end else if (smp_valid_i) begin
      top_prev_q <= smp_i[TOP];
    end
  end

  assign edge_o = smp_valid_i && smp_i[TOP] && !top_prev_q;
endmodule

// File: rtl/swm_accum.sv
module swm_accum #(
  parameter int NPH   = 8,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             edge_i,
  input  logic [NPH-1:0]   smp_i,
  input  logic             restart_i,
  input  logic [CNT_W-1:0] poll_i,
  output logic [NPH-1:0]   res_q_o,
  output logic             res_valid_o
);
  localparam int CW1 = CNT_W + 1;

  logic [NPH-1:0]   acc_q;
  logic [CNT_W-1:0] cnt_q;
  logic [NPH-1:0]   res_q;
  logic             rv_q;
  logic [CW1-1:0]   cnt_inc;
  logic             last_edge;
  logic [NPH-1:0]   acc_or;

  assign cnt_inc   = {1'b0, cnt_q} + CW1'(1);
  assign last_edge = cnt_inc >= {1'b0, poll_i};
  assign acc_or    = acc_q | smp_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      cnt_q <= '0;
      res_q <= '0;
      rv_q  <= 1'b0;
    end else begin
      rv_q <= 1'b0;
      if (restart_i) begin
        acc_q <= '0;
        cnt_q <= '0;
      end else if (edge_i) begin
        if (last_edge) begin
          res_q <= acc_or;
          rv_q  <= 1'b1;
          acc_q <= '0;
          cnt_q <= '0;
        end else begin
          acc_q <= acc_or;
          cnt_q <= cnt_inc[CNT_W-1:0];
        end
      end
    end
  end

  assign res_q_o     = res_q;
  assign res_valid_o = rv_q;
endmodule

// File: rtl/swm_classify.sv
module swm_classify
  import swm_pkg::*;
#(
  parameter int NPH = 8
) (
  input  logic [NPH-1:0] res_i,
  output logic [1:0]     state_o
);
  logic [NPH-2:0] step_ok;
  logic           thermo;

  // Each step upward must never go from 1 back to 0.
  for (genvar g = 0; g < NPH - 1; g++) begin : g_step
    assign step_ok[g] = !res_i[g] || res_i[g+1];
  end

  assign thermo = &step_ok;

  always_comb begin
    if (res_i == '0) begin
      state_o = ST_LEAD;
    end else if (&res_i) begin
      state_o = ST_LAG;
    end else if (thermo) begin
      state_o = ST_VIOL;
    end else begin
      state_o = ST_BAD;
    end
  end
endmodule

// File: rtl/swm_edge_monitor.sv
module swm_edge_monitor #(
  parameter int NPH   = 8,
  parameter int CNT_W = 8,
  localparam int DW   = (CNT_W > NPH) ? CNT_W : NPH
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             smp_valid_i,
  input  logic [NPH-1:0]   smp_i,
  input  logic             cfg_we_i,
  input  logic             cfg_addr_i,
  input  logic [CNT_W-1:0] cfg_wdata_i,
  output logic [DW-1:0]    cfg_rdata_o,
  output logic             res_valid_o,
  output logic [NPH-1:0]   res_data_o,
  output logic [1:0]       res_state_o
);
  logic             edge_w;
  logic             poll_we;
  logic [CNT_W-1:0] poll_q;
  logic [NPH-1:0]   res_q;

  swm_cfg_regs #(.CNT_W(CNT_W), .NPH(NPH), .DW(DW)) u_cfg (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_we_i   (cfg_we_i),
    .cfg_addr_i (cfg_addr_i),
    .cfg_wdata_i(cfg_wdata_i),
    .res_q_i    (res_q),
    .poll_q_o   (poll_q),
    .poll_we_o  (poll_we),
    .cfg_rdata_o(cfg_rdata_o)
  );

  swm_edge_det #(.NPH(NPH)) u_edge (
    .clk        (clk),
    .rst_n      (rst_n),
    .smp_valid_i(smp_valid_i),
    .smp_i      (smp_i),
    .edge_o     (edge_w)
  );

  swm_accum #(.NPH(NPH), .CNT_W(CNT_W)) u_acc (
    .clk        (clk),
    .rst_n      (rst_n),
    .edge_i     (edge_w),
    .smp_i      (smp_i),
    .restart_i  (poll_we),
    .poll_i     (poll_q),
    .res_q_o    (res_q),
    .res_valid_o(res_valid_o)
  );

  swm_classify #(.NPH(NPH)) u_cls (
    .res_i  (res_q),
    .state_o(res_state_o)
  );

  assign res_data_o = res_q;
endmodule

// File: rtl/swm_edge_monitor_chk.sv
module swm_edge_monitor_chk #(
  parameter int NPH   = 8,
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             res_valid,
  input logic [NPH-1:0]   res_data,
  input logic [1:0]       res_state,
  input logic             edge_w,
  input logic             poll_we,
  input logic [CNT_W-1:0] poll_q
);
  // R5
  rv_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid);

  // R5
  rv_from_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> $past(edge_w));

  // R6
  res_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid |-> $stable(res_data));

  // R8
  abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(poll_we) |-> !res_valid);

  // R2
  poll_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    poll_q != '0);

  // R9
  lag_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_state == 2'b10) |-> (&res_data));

  // R9
  lead_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_state == 2'b01) |-> (res_data == '0));
endmodule

bind swm_edge_monitor swm_edge_monitor_chk #(.NPH(NPH), .CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .res_valid(res_valid_o),
  .res_data (res_data_o),
  .res_state(res_state_o),
  .edge_w   (edge_w),
  .poll_we  (poll_we),
  .poll_q   (poll_q)
);

// File: tb/swm_edge_monitor_tb.sv
`timescale 1ns/1ps
module swm_edge_monitor_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       smp_valid_i = 1'b0;
  logic [7:0] smp_i = '0;
  logic       cfg_we_i = 1'b0;
  logic       cfg_addr_i = 1'b0;
  logic [7:0] cfg_wdata_i = '0;
  logic [7:0] cfg_rdata_o;
  logic       res_valid_o;
  logic [7:0] res_data_o;
  logic [1:0] res_state_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  swm_edge_monitor u_dut (
    .clk(clk), .rst_n(rst_n), .smp_valid_i(smp_valid_i), .smp_i(smp_i),
    .cfg_we_i(cfg_we_i), .cfg_addr_i(cfg_addr_i), .cfg_wdata_i(cfg_wdata_i),
    .cfg_rdata_o(cfg_rdata_o), .res_valid_o(res_valid_o),
    .res_data_o(res_data_o), .res_state_o(res_state_o)
  );

  // Reference model state
  bit       m_prev = 1'b1;
  bit [7:0] m_acc = '0;
  int       m_cnt = 0;
  int       m_poll = 1;
  bit [7:0] m_res = '0;
  bit       m_rv = 1'b0;

  function automatic bit [1:0] exp_state(bit [7:0] r);
    int first_one = 8;
    bit ok = 1'b1;
    if (r == 8'h00) return 2'b01;
    if (r == 8'hFF) return 2'b10;
    for (int i = 0; i < 8; i++) if (r[i] && first_one == 8) first_one = i;
    for (int i = 0; i < 8; i++) if ((i >= first_one) != r[i]) ok = 1'b0;
    return ok ? 2'b00 : 2'b11;
  endfunction

  task automatic check(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic model(bit v, bit [7:0] s, bit we, bit a, bit [7:0] wd);
    bit edg;
    edg = v && s[7] && !m_prev;
    if (v) m_prev = s[7];
    m_rv = 1'b0;
    if (we && a == 1'b0) begin
      m_poll = (wd == 0) ? 1 : int'(wd);
      m_acc = '0;
      m_cnt = 0;
    end else if (edg) begin
      if (m_cnt + 1 >= m_poll) begin
        m_res = m_acc | s;
        m_rv = 1'b1;
        m_acc = '0;
        m_cnt = 0;
      end else begin
        m_acc = m_acc | s;
        m_cnt++;
      end
    end
  endtask

  // One cycle: drive after a falling edge, compare after the next one.
  task automatic step(bit v, bit [7:0] s, bit we = 0, bit a = 0, bit [7:0] wd = 0,
                      string tag = "R5");
    smp_valid_i = v; smp_i = s; cfg_we_i = we; cfg_addr_i = a; cfg_wdata_i = wd;
    model(v, s, we, a, wd);
    @(negedge clk);
    cfg_we_i = 1'b0;
    check({tag, " res_valid"}, res_valid_o, m_rv);
    check({tag, " res_data"}, res_data_o, m_res);
    check("R9 state", res_state_o, exp_state(m_res));
  endtask

  task automatic rd(bit a, int exp, string tag);
    cfg_addr_i = a;
    #0.5;
    check(tag, cfg_rdata_o, exp);
  endtask

  task automatic pulse(bit [7:0] s, string tag = "R5");
    step(1, 8'h00, .tag(tag));
    step(1, s, .tag(tag));
  endtask

  initial begin
    #400000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    smp_valid_i = 1'b1; smp_i = 8'hFF;   // pulse high through reset
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    check("R1 res_valid", res_valid_o, 0);
    check("R1 res_data", res_data_o, 0);
    check("R1 state", res_state_o, 2'b01);
    rd(0, 1, "R1 poll read");
    rd(1, 0, "R1 result read");
    // R4: pulse high since reset, no edge
    step(1, 8'hFF, .tag("R4"));
    step(1, 8'hFF, .tag("R4"));
    // R3: write to result ignored
    step(0, 8'h00, 1, 1, 8'hAA, "R3");
    rd(1, 0, "R3 result unchanged");
    rd(0, 1, "R3 poll unchanged");
    // poll 1: lagging, violation, invalid patterns
    pulse(8'hFF); step(1, 8'hFF);
    pulse(8'hF0, "R9");
    pulse(8'h80, "R9");
    pulse(8'hB0, "R9");
    pulse(8'h81, "R9");
    rd(1, 8'h81, "R3 result read");
    // R2: write 0 reads 1; write 3
    step(1, 8'h00, 1, 0, 8'h00, "R2");
    rd(0, 1, "R2 zero->1");
    step(1, 8'h00, 1, 0, 8'h03, "R2");
    rd(0, 3, "R2 poll read");
    // R5/R7: three captures ORed, then an automatic second window
    pulse(8'hC0); pulse(8'hE0); pulse(8'hF0);
    pulse(8'h80, "R7"); pulse(8'hFC, "R7"); pulse(8'hC0, "R7");
    // R8: abort mid-window and coincident edge
    pulse(8'hFF, "R8");
    step(1, 8'h00, 1, 0, 8'h02, "R8");
    step(1, 8'hF8, 1, 0, 8'h02, "R8");  // edge with write: dropped
    pulse(8'hF0, "R8"); pulse(8'hE0, "R8");
    // R10: invalid samples ignored
    step(1, 8'h00, 1, 0, 8'h01, "R10");
    step(0, 8'h80, .tag("R10"));
    step(1, 8'h80, .tag("R10"));        // edge vs last valid 0
    step(1, 8'hC0, .tag("R10"));
    step(0, 8'h00, .tag("R10"));
    step(1, 8'hFF, .tag("R10"));        // no edge: last valid top bit 1
    // Constrained random phase
    for (int n = 0; n < 4000; n++) begin
      bit v;
      bit [7:0] s;
      bit we;
      int k;
      v = ($urandom_range(0, 9) < 8);
      k = $urandom_range(0, 3);
      if ($urandom_range(0, 1) == 0) s = {1'b0, 7'($urandom)};
      else if (k == 0) s = 8'hFF << $urandom_range(0, 7);
      else if (k == 1) s = 8'hFF;
      else s = {1'b1, 7'($urandom)};
      we = ($urandom_range(0, 99) < 2);
      step(v, s, we, 1'($urandom_range(0, 1)), 8'($urandom_range(0, 5)), "R5 random");
    end
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED1234));
  end
endmodule